// File: doc/BRIEF.md
# Daisy-Chain SPI Frame Encoder

This block drives one SPI bus shared by a chain of LED backlight driver devices. A caller presents a command, a target device ID, a register address, a byte count and a flat write buffer, and pulses `start`. The block validates the request. It then builds every byte of the frame, shifts the bytes out in SPI mode 0 with chip select held low, and pulses `done` once the last frame has finished. For reads, it collects the reply bytes from the tail of the returned stream.

Four commands exist: unicast write, unicast read, broadcast write of the same data to every device, and broadcast write with a separate data block per device. Each frame adds trailing zero bytes so the stream can pass along the chain. The number of zero bytes depends on the command and on the target's position in the chain. Reads of upper-bank registers (address bit 7 set) are wrapped in two extra unicast frames. The first opens the upper bank and the last closes it again.

Top module: `chain_spi_framer`

## Requirements
- R1: The first byte of every frame is {broadcast, single, id[5:0]}. Bit 7 is 1 for broadcast commands (`cmd` 2 and 3) and 0 otherwise. Bit 6 is 1 when the length is 1. `cmd` encodes 0 = unicast write, 1 = unicast read, 2 = broadcast same-data write and 3 = broadcast per-device write.
- R2: A unicast command (`cmd` 0 or 1) with `dev_id` 0x00 or 0x3F raises `err` for one cycle in the cycle after `start`, and no frame begins (`cs_n` stays high).
- R3: A length of 0, or a length above MAXLEN, raises `err` in the same way, and no frame begins.
- R4: A length-1 frame is header, register byte, data byte. A longer frame is header, length byte, register byte, data bytes.
- R5: The register byte holds the address in bits 6:0. Bit 7 is 1 for a read and 0 for a write.
- R6: After its data, a unicast write to ID k sends k-1 zero bytes, and a broadcast write sends NDEV-1 zero bytes.
- R7: A read sends NDEV+len zero bytes after the register byte. `rd_data` byte j (bits 8j+7:8j) receives the byte read on the bus at position total-len+j of the frame.
- R8: A per-device broadcast sends NDEV*len data bytes taken in order from `wr_data` byte 0 upward, with header ID 0x3F. A same-data broadcast sends len bytes with header ID 0x00. For both broadcasts the `dev_id` input is ignored.
- R9: A read with address bit 7 set is framed three times, in this order: a single write of 0x80 to register 0x78 of the same device, the read, then a single write of 0x00 to register 0x78. Chip select goes high between the frames.
- R10: SPI mode 0 applies: `sclk` idles low, `mosi` changes only while `sclk` is low and is sent MSB first, and `miso` is sampled on the rising edge. `cs_n` stays low for a whole frame. `done` pulses for one cycle when the last frame ends, and `busy` is high from the cycle after an accepted `start` until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| cmd | input | 2 | Command code (see R1) |
| dev_id | input | 6 | Target device ID for unicast commands |
| reg_addr | input | 8 | Register address |
| len | input | $clog2(MAXLEN+1) | Bytes per device |
| wr_data | input | 8*NDEV*MAXLEN | Write buffer, byte 0 in bits 7:0 |
| miso | input | 1 | Serial data from the chain |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the chain |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the request completes |
| err | output | 1 | One-cycle pulse when a request is rejected |
| rd_data | output | 8*MAXLEN | Bytes returned by the last read |

## Verification
A wrong byte index or a wrong length field shows up on `mosi` within the eight serial clocks of the byte concerned. The bench's per-byte comparison reports it on the edge where that byte completes. A wrong padding count or a wrong stage sequence shows up when `cs_n` rises, as a frame with the wrong length or an extra or missing frame. A misplaced read capture window is visible only in `rd_data`, after `done`, because the reply pattern differs at every stream position.

// File: rtl/chain_spi_framer.sv
module chain_spi_framer #(
  parameter int NDEV = 4,
  parameter int MAXLEN = 8,
  parameter int DIV = 2,
  localparam int LW = $clog2(MAXLEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               cmd,
  input  logic [5:0]               dev_id,
  input  logic [7:0]               reg_addr,
  input  logic [LW-1:0]            len,
  input  logic [8*NDEV*MAXLEN-1:0] wr_data,
  input  logic                     miso,
  output logic                     sclk,
  output logic                     cs_n,
  output logic                     mosi,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic [8*MAXLEN-1:0]      rd_data
);
  localparam int BUFB = NDEV * MAXLEN;
  localparam int IW = $clog2(BUFB + NDEV + MAXLEN + 72);
  localparam int TW = $clog2(DIV + 1);

  typedef enum logic [1:0] {IDLE, LOAD, XFER, GAP} st_t;
  st_t st;
  logic [1:0] stage, c_cmd;
  logic [5:0] c_id;
  logic [7:0] c_reg, sh, rx;
  logic [LW-1:0] c_len;
  logic [8*BUFB-1:0] c_buf;
  logic [IW-1:0] idx;
  logic [2:0] bitc;
  logic [TW-1:0] tcnt;
  logic sclk_q, done_q, err_q;
  logic [8*MAXLEN-1:0] rd_q;

  wire sw = stage != 2'd1;
  wire f_rd = !sw && c_cmd == 2'd1;
  wire f_bc = !sw && c_cmd[1];
  wire f_single = sw || c_len == LW'(1);
  wire hi = c_cmd == 2'd1 && c_reg[7];
  wire [5:0] f_id = (!sw && c_cmd == 2'd3) ? 6'h3F : (!sw && c_cmd == 2'd2) ? 6'h00 : c_id;
  wire [IW-1:0] f_hs = f_single ? IW'(2) : IW'(3);
  wire [IW-1:0] f_dcnt = sw ? IW'(1) : f_rd ? IW'(0) :
                         (c_cmd == 2'd3 ? IW'(NDEV) * IW'(c_len) : IW'(c_len));
  wire [IW-1:0] f_pad = f_rd ? IW'(NDEV) + IW'(c_len) : f_bc ? IW'(NDEV - 1) : IW'(c_id) - IW'(1);
  wire [IW-1:0] f_total = f_hs + f_dcnt + f_pad;
  wire [7:0] f_regb = sw ? 8'h78 : {f_rd, c_reg[6:0]};
  wire bad = len == '0 || len > LW'(MAXLEN) || (!cmd[1] && (dev_id == 6'h00 || dev_id == 6'h3F));
  wire tick = tcnt == TW'(DIV - 1);
  wire [IW-1:0] ri = idx - (f_total - IW'(c_len));

  function automatic logic [7:0] byte_at(input logic [IW-1:0] i);
    logic [IW-1:0] di;
    di = i - f_hs;
    if (i == '0) return {f_bc, f_single, f_id};
    else if (!f_single && i == IW'(1)) return 8'(c_len);
    else if (i == f_hs - IW'(1)) return f_regb;
    else if (i < f_hs + f_dcnt) return sw ? (stage == 2'd0 ? 8'h80 : 8'h00) : 8'(c_buf >> {di, 3'b000});
    else return 8'h00;
  endfunction

  assign sclk = sclk_q;
  assign cs_n = st != XFER;
  assign mosi = sh[7];
  assign busy = st != IDLE;
  assign done = done_q;
  assign err = err_q;
  assign rd_data = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; stage <= 2'd1; c_cmd <= '0; c_id <= '0; c_reg <= '0; c_len <= '0;
      c_buf <= '0; idx <= '0; bitc <= '0; tcnt <= '0; sclk_q <= 1'b0; sh <= '0; rx <= '0;
      done_q <= 1'b0; err_q <= 1'b0; rd_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (bad) err_q <= 1'b1;
          else begin
            c_cmd <= cmd; c_id <= dev_id; c_reg <= reg_addr; c_len <= len; c_buf <= wr_data;
            stage <= (cmd == 2'd1 && reg_addr[7]) ? 2'd0 : 2'd1;
            if (cmd == 2'd1) rd_q <= '0;
            st <= LOAD;
          end
        end
        LOAD: begin
          sh <= byte_at('0); idx <= '0; bitc <= '0; tcnt <= '0; sclk_q <= 1'b0; st <= XFER;
        end
        XFER: begin
          tcnt <= tick ? '0 : tcnt + TW'(1);
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx <= {rx[6:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (bitc == 3'd7) begin
                if (f_rd && idx >= f_total - IW'(c_len))
                  for (int k = 0; k < MAXLEN; k++)
                    if (ri == IW'(k)) rd_q[8*k +: 8] <= rx;
                if (idx == f_total - IW'(1)) begin
                  tcnt <= '0;
                  if (hi && stage != 2'd2) begin
                    stage <= stage + 2'd1;
                    st <= GAP;
                  end else begin
                    st <= IDLE;
                    done_q <= 1'b1;
                  end
                end else begin
                  idx <= idx + IW'(1);
                  sh <= byte_at(idx + IW'(1));
                  bitc <= '0;
                end
              end else begin
                sh <= {sh[6:0], 1'b0};
                bitc <= bitc + 3'd1;
              end
            end
          end
        end
        GAP: begin
          tcnt <= tick ? '0 : tcnt + TW'(1);
          if (tick) st <= LOAD;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r10_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  a_r10_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!busy && cs_n));
  a_r3_err_not_done: assert property (@(posedge clk) disable iff (!rst_n) err |-> !done);
  a_r10_done_cs: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n);
endmodule

// File: tb/test_chain_spi_framer.sv
module test_chain_spi_framer;
  localparam int NDEV = 4, MAXLEN = 8, DIV = 2;
  localparam int LW = $clog2(MAXLEN + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cmd = 0;
  logic [5:0] dev_id = 0;
  logic [7:0] reg_addr = 0;
  logic [LW-1:0] len = 0;
  logic [8*NDEV*MAXLEN-1:0] wr_data;
  logic miso, sclk, cs_n, mosi, busy, done, err;
  logic [8*MAXLEN-1:0] rd_data;

  chain_spi_framer #(.NDEV(NDEV), .MAXLEN(MAXLEN), .DIV(DIV)) i_chain_spi_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .dev_id(dev_id), .reg_addr(reg_addr),
    .len(len), .wr_data(wr_data), .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data));

  always #5 clk = ~clk;

  int total = 0, nbad = 0, cyc = 0;
  byte unsigned exp_q[$];
  int flen_q[$];
  byte unsigned exp_rd[MAXLEN];
  string cur_tag = "R10";
  int nbit = 0, nbyte = 0;
  logic [7:0] cur = 0;
  logic p_sclk = 0, p_cs = 1;

  function automatic byte unsigned pat(int p);
    return 8'(p * 37 + 11);
  endfunction
  function automatic byte unsigned wb(int j);
    return 8'(j * 29 + 3);
  endfunction

  always_comb miso = pat(nbyte)[7 - nbit[2:0]];

  task automatic chk(string tag, logic ok, longint got, longint ex);
    total++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, ex);
    end
  endtask

  always @(negedge clk) begin
    if (!cs_n && sclk && !p_sclk) begin
      cur = {cur[6:0], mosi};
      nbit++;
      if (nbit == 8) begin
        if (exp_q.size() == 0) chk({cur_tag, " extra byte"}, 0, cur, 0);
        else begin
          byte unsigned e;
          e = exp_q.pop_front();
          chk({cur_tag, " stream byte"}, cur == e, cur, e);
        end
        nbit = 0;
        nbyte++;
      end
    end
    if (cs_n && !p_cs) begin
      if (flen_q.size() == 0) chk({cur_tag, " extra frame"}, 0, nbyte, 0);
      else begin
        int fl;
        fl = flen_q.pop_front();
        chk({cur_tag, " frame length"}, nbyte == fl, nbyte, fl);
      end
    end
    if (cs_n) begin nbit = 0; nbyte = 0; end
    p_sclk = sclk;
    p_cs = cs_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nbad++;
      $display("FAIL R10 watchdog got=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, nbad);
      $finish;
    end
  end

  task automatic sw_frame(int id, byte unsigned v);
    exp_q.push_back(8'h40 | 8'(id));
    exp_q.push_back(8'h78);
    exp_q.push_back(v);
    for (int j = 0; j < id - 1; j++) exp_q.push_back(8'h00);
    flen_q.push_back(3 + id - 1);
  endtask

  task automatic run(string tag, int c, int id, int rg, int ln, bit is_bad);
    cur_tag = tag;
    if (!is_bad) begin
      bit single, rd, bc;
      int cnt, idv, n, pad;
      single = (ln == 1); rd = (c == 1); bc = (c >= 2);
      if (rd && rg >= 128) sw_frame(id, 8'h80);
      idv = (c == 3) ? 63 : (c == 2) ? 0 : id;
      exp_q.push_back(8'(bc) << 7 | 8'(single) << 6 | 8'(idv)); cnt = 1;
      if (!single) begin exp_q.push_back(8'(ln)); cnt++; end
      exp_q.push_back(8'(rg & 127) | (rd ? 8'h80 : 8'h00)); cnt++;
      if (!rd) begin
        n = (c == 3) ? NDEV * ln : ln;
        for (int j = 0; j < n; j++) begin exp_q.push_back(wb(j)); cnt++; end
      end
      pad = rd ? NDEV + ln : bc ? NDEV - 1 : id - 1;
      for (int j = 0; j < pad; j++) begin exp_q.push_back(8'h00); cnt++; end
      flen_q.push_back(cnt);
      for (int j = 0; j < ln && j < MAXLEN; j++) exp_rd[j] = pat(cnt - ln + j);
      if (rd && rg >= 128) sw_frame(id, 8'h00);
    end
    @(negedge clk);
    cmd = 2'(c); dev_id = 6'(id); reg_addr = 8'(rg); len = LW'(ln); start = 1;
    @(negedge clk);
    start = 0;
    if (is_bad) begin
      bit low;
      chk({tag, " err pulse"}, err == 1, err, 1);
      low = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (!cs_n || busy) low = 1; end
      chk({tag, " no transfer after reject"}, low == 0, low, 0);
    end else begin
      int k;
      chk({tag, " busy after start"}, busy == 1 && err == 0, busy, 1);
      k = 0;
      while (!done && k < 20000) begin @(negedge clk); k++; end
      chk({tag, " done seen"}, done == 1, done, 1);
      @(negedge clk);
      chk({tag, " done one cycle"}, done == 0 && busy == 0, done, 0);
      chk({tag, " all bytes sent"}, exp_q.size() == 0, exp_q.size(), 0);
      chk({tag, " all frames sent"}, flen_q.size() == 0, flen_q.size(), 0);
      if (c == 1)
        for (int j = 0; j < ln; j++)
          chk({tag, " read byte"}, rd_data[8*j +: 8] == exp_rd[j], rd_data[8*j +: 8], exp_rd[j]);
      exp_q.delete();
      flen_q.delete();
    end
  endtask

  initial begin
    for (int j = 0; j < NDEV * MAXLEN; j++) wr_data[8*j +: 8] = wb(j);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset idle", cs_n == 1 && sclk == 0 && busy == 0 && done == 0 && err == 0, {cs_n, sclk, busy, done, err}, 5'b10000);
    chk("R7 reset rd_data", rd_data == '0, rd_data, 0);
    run("R4 R1 R6 unicast single write", 0, 3, 8'h12, 1, 0);
    run("R4 R6 unicast block write", 0, 2, 8'h40, 4, 0);
    run("R6 unicast write far id", 0, 6, 8'h21, 3, 0);
    run("R5 R7 unicast single read", 1, 1, 8'h05, 1, 0);
    run("R5 R7 unicast block read", 1, 4, 8'h33, 3, 0);
    run("R8 R11 broadcast same single", 2, 63, 8'h00, 1, 0);
    run("R8 R6 broadcast same block", 2, 0, 8'h10, 2, 0);
    run("R8 per-device block", 3, 0, 8'h40, 2, 0);
    run("R8 per-device single", 3, 5, 8'h41, 1, 0);
    run("R9 upper read", 1, 2, 8'h85, 2, 0);
    run("R9 upper read single", 1, 3, 8'hB3, 1, 0);
    run("R2 unicast id zero", 0, 0, 8'h01, 1, 1);
    run("R2 read id 3f", 1, 63, 8'h01, 1, 1);
    run("R3 zero length", 2, 0, 8'h01, 0, 1);
    run("R3 oversize length", 0, 1, 8'h01, 9, 1);
    run("R7 read max length", 1, 2, 8'h00, MAXLEN, 0);
    $display("  test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end
endmodule